// File: doc/BRIEF.md
# Cascaded Decade Switch Scanner

This block scans a field of up to one hundred single-contact switches through one shared return wire. A low ring sequencer enables one of ten switch lines at a time. A high ring sequencer picks one of ten banks and steps only when the low ring rolls over from its last line. Every switch joins its line, through its bank, to the single sense input. A scan counter runs from 0 to 99 beside the two rings. Each scan tick closes a slot. If the sense input is active in that slot, the count of the slot is latched as the pressed switch index and flagged with a one-cycle valid strobe.

The drive outputs are active-high enables for open-drain or isolated one-way drivers, so two switches pressed together cannot make two outputs fight. Each pressed switch is sensed in its own slot, so several pressed switches each give one report per 100-slot frame, in ascending index order. Debounce is left to the logic that consumes the reports.

Top module: `decade_scan_top`

## Requirements
- R1: After a synchronous reset, lineEn is 0x001 (line 0), bankEn is 0x001 (bank 0), keyValid is 0 and keyIndex is 0.
- R2: lineEn always has exactly one bit set. Bit k means line k is driven. On each cycle with scanTick high it moves from bit k to bit k+1, and from bit 9 back to bit 0.
- R3: bankEn always has exactly one bit set. It moves to the next bit (9 wraps to 0) only on a tick that takes lineEn from bit 9 to bit 0, and holds on every other cycle.
- R4: On cycles with scanTick low, lineEn, bankEn and keyValid do not change and no index is captured, even while senseIn is high.
- R5: senseIn is sampled only on a cycle with scanTick high, which is the last cycle of the slot. If it is high, then on the next cycle keyValid is 1 and keyIndex equals 10*b + k, where bankEn bit b and lineEn bit k were set during that slot.
- R6: keyValid is a one-cycle pulse. It is 0 on any cycle that does not follow a capture.
- R7: With several switches pressed, each is reported exactly once per 100-tick frame, in ascending index order.
- R8: After 100 ticks the scan is back at line 0 of bank 0, so every frame starts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scanTick | input | 1 | Closes the current slot and advances the scan |
| senseIn | input | 1 | Shared switch return, active high |
| lineEn | output | 10 | One-hot switch line enable |
| bankEn | output | 10 | One-hot bank enable |
| keyIndex | output | 7 | Captured switch index, 0 to 99 |
| keyValid | output | 1 | One-cycle strobe for a new keyIndex |

## Verification
The hardest case to reach from the ports is several switches held down at once, spread across banks and at the bank edges (index 9 to 10, and 99 wrapping to 0). The sense line is then active in several slots of one frame, so an error in the carry or in the capture shows up as a missing, duplicated or shifted report. The bench models the switch matrix. It drives senseIn from the live lineEn and bankEn outputs and a pressed-switch mask. It then runs whole frames for a table of masks and compares every reported index, in order, with the indices in the mask.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic advance;  // close the current slot and step the rings
    logic capture;  // latch the current count as a pressed index
  } scanStrobe_t;
endpackage

// File: rtl/scan_ring.sv
module scan_ring #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [N-1:0] ring,
  output logic         atLast
);
  generate
    if (N == 1) begin : g_single
      always_ff @(posedge clk) ring <= 1'b1;
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)       ring <= {{(N-1){1'b0}}, 1'b1};
        else if (step) ring <= {ring[N-2:0], ring[N-1]};
      end
    end
  endgenerate

  assign atLast = ring[N-1];

  // R2/R3: exactly one position active at all times
  assert_ring_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(ring) == 1);
  // R4: without a step the ring holds
  assert_ring_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ring));
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        scanTick,
  input  logic        senseIn,
  output scanStrobe_t strobe
);
  // The tick cycle is the last cycle of a slot, so the drive has settled
  always_comb begin
    strobe.advance = scanTick;
    strobe.capture = scanTick & senseIn;
  end

  // R5: a capture only happens at the close of a slot
  assert_capture_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |-> strobe.advance);
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int NUM_LINES = 10,
  parameter int NUM_BANKS = 10,
  localparam int TOTAL = NUM_LINES * NUM_BANKS,
  localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  scanStrobe_t          strobe,
  output logic [NUM_LINES-1:0] lineEn,
  output logic [NUM_BANKS-1:0] bankEn,
  output logic [IDX_W-1:0]     keyIndex,
  output logic                 keyValid
);
  logic             lineLast, bankLast, carry;
  logic [IDX_W-1:0] scanCount;

  assign carry = strobe.advance & lineLast;

  scan_ring #(.N(NUM_LINES)) u_lineRing (
    .clk(clk), .rst(rst), .step(strobe.advance), .ring(lineEn), .atLast(lineLast)
  );

  scan_ring #(.N(NUM_BANKS)) u_bankRing (
    .clk(clk), .rst(rst), .step(carry), .ring(bankEn), .atLast(bankLast)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scanCount <= '0;
    end else if (strobe.advance) begin
      if (scanCount == IDX_W'(TOTAL - 1)) scanCount <= '0;
      else                                scanCount <= scanCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      keyIndex <= '0;
      keyValid <= 1'b0;
    end else begin
      keyValid <= strobe.capture;
      if (strobe.capture) keyIndex <= scanCount;
    end
  end

  // Position of the active bit of each ring, for cross-checking the counter
  function automatic int onehotPos(input logic [31:0] vec);
    int p = 0;
    for (int i = 0; i < 32; i++) if (vec[i]) p = i;
    return p;
  endfunction

  // R5: counter agrees with bank*lines + line
  assert_count_matches_rings_R5: assert property (@(posedge clk) disable iff (rst)
    int'(scanCount) == onehotPos(32'(bankEn)) * NUM_LINES + onehotPos(32'(lineEn)));
  // R3: bank ring moves only on the carry out of the line ring
  assert_bank_on_carry_R3: assert property (@(posedge clk) disable iff (rst)
    !carry |=> $stable(bankEn));
  // R8: last slot of the frame wraps to slot 0
  assert_frame_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (carry && bankLast) |=> (scanCount == '0));
  // R6: strobe never lasts past a cycle without a capture
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> !keyValid);
  // R5: reported index is the slot that was closing
  assert_capture_index_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> (keyValid && keyIndex == $past(scanCount)));
endmodule

// File: rtl/decade_scan_top.sv
module decade_scan_top
  import scan_pkg::*;
#(
  parameter int NUM_LINES = 10,
  parameter int NUM_BANKS = 10,
  localparam int IDX_W = (NUM_LINES * NUM_BANKS > 1) ? $clog2(NUM_LINES * NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scanTick,
  input  logic                 senseIn,
  output logic [NUM_LINES-1:0] lineEn,
  output logic [NUM_BANKS-1:0] bankEn,
  output logic [IDX_W-1:0]     keyIndex,
  output logic                 keyValid
);
  scanStrobe_t strobe;

  scan_ctrl u_ctrl (
    .clk(clk), .rst(rst), .scanTick(scanTick), .senseIn(senseIn), .strobe(strobe)
  );

  scan_datapath #(.NUM_LINES(NUM_LINES), .NUM_BANKS(NUM_BANKS)) u_datapath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .lineEn(lineEn), .bankEn(bankEn), .keyIndex(keyIndex), .keyValid(keyValid)
  );
endmodule

// File: tb/decade_scan_top_tb.sv
module decade_scan_top_tb;
  localparam int NV = 7;
  // Pressed switches per vector (-1 = unused), ascending = expected report order
  localparam int KEY_A [NV] = '{0,  9, 10, 57, 99,  3, 0};
  localparam int KEY_B [NV] = '{-1, -1, -1, -1, -1, 42, 9};
  localparam int KEY_C [NV] = '{-1, -1, -1, -1, -1, 77, 99};

  logic clk = 1'b0, rst = 1'b1, scanTick = 1'b0, senseIn;
  logic [9:0] lineEn, bankEn;
  logic [6:0] keyIndex;
  logic keyValid;
  logic [99:0] pressed = '0;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  decade_scan_top u_dut (
    .clk(clk), .rst(rst), .scanTick(scanTick), .senseIn(senseIn),
    .lineEn(lineEn), .bankEn(bankEn), .keyIndex(keyIndex), .keyValid(keyValid)
  );

  // Switch matrix model: a pressed switch joins its line to the sense return
  always_comb begin
    senseIn = 1'b0;
    for (int b = 0; b < 10; b++)
      for (int k = 0; k < 10; k++)
        if (pressed[b*10+k] && bankEn[b] && lineEn[k]) senseIn = 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run one 100-tick frame with a tick every other cycle
  task automatic runFrame(input int e0, input int e1, input int e2);
    int got [3];
    int nGot = 0, seqErr = 0, holdErr = 0, pulseErr = 0;
    int exp [3] = '{e0, e1, e2};
    int nExp = (e0 >= 0) + (e1 >= 0) + (e2 >= 0);
    for (int s = 0; s < 100; s++) begin
      if (lineEn != 10'(1 << (s % 10)) || bankEn != 10'(1 << (s / 10))) seqErr++;
      scanTick = 1'b1;
      @(posedge clk); @(negedge clk);
      scanTick = 1'b0;
      if (keyValid) begin
        if (nGot < 3) got[nGot] = int'(keyIndex);
        nGot++;
      end
      @(posedge clk); @(negedge clk);
      if (keyValid) pulseErr++;
      if (lineEn != 10'(1 << ((s + 1) % 10))) holdErr++;
    end
    check("R2/R3 drive sequence errors", seqErr, 0);
    check("R4 hold on idle cycle errors", holdErr, 0);
    check("R6 valid beyond one cycle", pulseErr, 0);
    check("R7 report count", nGot, nExp);
    for (int i = 0; i < 3; i++)
      if (i < nExp && i < nGot) check("R5/R7 reported index", got[i], exp[i]);
    check("R8 lineEn at frame start", int'(lineEn), 1);
    check("R8 bankEn at frame start", int'(bankEn), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 lineEn", int'(lineEn), 1);
    check("R1 bankEn", int'(bankEn), 1);
    check("R1 keyValid", int'(keyValid), 0);
    check("R1 keyIndex", int'(keyIndex), 0);

    // Vector table of pressed-switch sets, one frame each
    for (int v = 0; v < NV; v++) begin
      pressed = '0;
      if (KEY_A[v] >= 0) pressed[KEY_A[v]] = 1'b1;
      if (KEY_B[v] >= 0) pressed[KEY_B[v]] = 1'b1;
      if (KEY_C[v] >= 0) pressed[KEY_C[v]] = 1'b1;
      runFrame(KEY_A[v], KEY_B[v], KEY_C[v]);
    end

    // R4: sense active with no tick captures nothing and moves nothing
    pressed = '0;
    pressed[0] = 1'b1;
    begin
      int seen = 0;
      for (int c = 0; c < 20; c++) begin
        @(posedge clk); @(negedge clk);
        if (keyValid) seen++;
      end
      check("R4 no capture without tick", seen, 0);
      check("R4 lineEn held", int'(lineEn), 1);
      check("R4 bankEn held", int'(bankEn), 1);
    end

    // R5/R6: back-to-back ticks over two pressed adjacent slots 0 and 1
    pressed[1] = 1'b1;
    scanTick = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R5 first adjacent valid", int'(keyValid), 1);
    check("R5 first adjacent index", int'(keyIndex), 0);
    @(posedge clk); @(negedge clk);
    scanTick = 1'b0;
    check("R5 second adjacent valid", int'(keyValid), 1);
    check("R5 second adjacent index", int'(keyIndex), 1);
    @(posedge clk); @(negedge clk);
    check("R6 valid drops", int'(keyValid), 0);
    check("R6 index held", int'(keyIndex), 1);

    // R1: reset mid-scan returns to slot 0
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 lineEn after mid-scan reset", int'(lineEn), 1);
    check("R1 keyValid after mid-scan reset", int'(keyValid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule